// File: doc/BRIEF.md
# Receive Mailbox Acceptance Filter

This block decides where a received standard-format CAN frame is stored once its CRC has been found correct. It holds 32 receive mailboxes by default. Each has an 11-bit identifier, an 11-bit per-bit don't-care mask, an enable bit and a frame-type bit. When a CRC-ok strobe arrives, the block latches the frame's identifier and frame type. It then walks the mailboxes one per clock, from the highest index down, and stops at the first mailbox that accepts the frame. The winning index is reported on a one-cycle store strobe, which tells the message storage where the payload goes.

Each accepted frame sets the winner's bit in a receive-done vector. Software clears these bits by writing ones to them. The receive interrupt is the OR of the done bits whose per-mailbox interrupt enable is set, gated by a global enable. The acknowledge decision depends only on the CRC result and is independent of acceptance.

Top module: `rx_accept_filter`

## Requirements
- R1: A mailbox accepts a frame when, for every bit whose mask bit is 0, the received identifier bit equals the mailbox identifier bit. Mask bits at 1 are don't-care. With identifier 0x2AA and mask 0x003, exactly the identifiers 0x2A8 to 0x2AB are accepted.
- R2: When several mailboxes accept a frame, `store_idx` reports the highest-numbered one.
- R3: A search starts only on a `crc_ok` pulse. Without it, no store strobe is issued and `rx_done` does not change, whatever `frm_id` holds.
- R4: `ack` is high in the cycle after every `crc_ok` pulse, whether or not any mailbox accepts the frame.
- R5: A mailbox takes part in matching only if its enable bit is set. It accepts remote frames only if its type bit is 1 and data frames only if its type bit is 0. The control write (`cfg_sel`=2) carries enable in `cfg_wdata[0]` and type in `cfg_wdata[1]`. `cfg_sel`=0 writes the identifier and `cfg_sel`=1 writes the mask.
- R6: `busy` rises in the cycle after an accepted `crc_ok`. The search ends, with `busy` low, within NMB cycles after that. A `crc_ok` that arrives while `busy` is high does not start or alter a search. `store_vld` is a one-cycle pulse that coincides with `busy` falling.
- R7: `rx_done[k]` is set one cycle after a store strobe with index k. Writing ones through `done_clr_we`/`done_clr` clears the corresponding bits, and a set takes priority over a clear in the same cycle.
- R8: `rx_irq` is high exactly when `irq_gen` is 1 and some bit k has both `rx_done[k]` and `irq_mb_en[k]` set.
- R9: When no mailbox accepts a frame, the search ends with no store strobe and `rx_done` unchanged.
- R10: After reset all outputs are 0 and every mailbox is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Mailbox configuration write strobe |
| cfg_sel | input | 2 | Field select: 0 identifier, 1 mask, 2 control |
| cfg_idx | input | 5 | Mailbox index for the configuration write |
| cfg_wdata | input | 11 | Configuration write data |
| irq_mb_we | input | 1 | Write strobe for per-mailbox interrupt enables |
| irq_mb_wdata | input | 32 | Per-mailbox interrupt enables (1 = enabled) |
| irq_gen_we | input | 1 | Write strobe for the global interrupt enable |
| irq_gen_wdata | input | 1 | Global interrupt enable (1 = enabled) |
| done_clr_we | input | 1 | Write strobe for clearing receive-done bits |
| done_clr | input | 32 | Ones clear the matching receive-done bits |
| frm_id | input | 11 | Identifier of the received frame |
| frm_remote | input | 1 | 1 = remote frame, 0 = data frame |
| crc_ok | input | 1 | One-cycle pulse: frame CRC correct |
| ack | output | 1 | Acknowledge decision, one cycle after `crc_ok` |
| busy | output | 1 | Search in progress |
| store_vld | output | 1 | One-cycle pulse: store the frame in `store_idx` |
| store_idx | output | 5 | Winning mailbox index |
| rx_done | output | 32 | Receive-done flags |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
Directed frames reuse the two-mailbox layout with 0x2AA: one mailbox exact, one with the low two bits don't-care. They show the mask rule, the highest-index tie-break and a near-miss identifier that no mailbox accepts. Further directed cases disable a mailbox, flip the frame type, hold an identifier without a CRC pulse and send a second pulse during a long search. These cases tell enable, type, strobe gating and busy behaviour apart. Random tables pair frames copied from a mailbox's identifier, with random flips in masked or unmasked bits, against fully random identifiers. This separates genuine mask handling from accidental hits. Every result is compared with the index, done vector and interrupt that a bench model predicts.

// File: rtl/canf_pkg.sv
package canf_pkg;
   typedef enum logic [1:0] {
      FLD_ID   = 2'd0,
      FLD_MASK = 2'd1,
      FLD_CTRL = 2'd2
   } cfg_field_e;
endpackage

// File: rtl/canf_cfg_bank.sv
module canf_cfg_bank
   import canf_pkg::*;
#(
   parameter int NMB  = 32,
   parameter int ID_W = 11,
   localparam int IW  = $clog2(NMB)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [1:0]                sel,
   input  logic [IW-1:0]             idx,
   input  logic [ID_W-1:0]           wdata,
   output logic [NMB-1:0][ID_W-1:0]  mb_id,
   output logic [NMB-1:0][ID_W-1:0]  mb_msk,
   output logic [NMB-1:0]            mb_en,
   output logic [NMB-1:0]            mb_rtr
);
   for (genvar i = 0; i < NMB; i++) begin : g_mb
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mb_id[i]  <= '0;
            mb_msk[i] <= '0;
            mb_en[i]  <= 1'b0;
            mb_rtr[i] <= 1'b0;
         end else if (we && idx == IW'(i)) begin
            case (cfg_field_e'(sel))
               FLD_ID:   mb_id[i]  <= wdata;
               FLD_MASK: mb_msk[i] <= wdata;
               FLD_CTRL: begin
                  mb_en[i]  <= wdata[0];
                  mb_rtr[i] <= wdata[1];
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/canf_scan.sv
module canf_scan #(
   parameter int NMB  = 32,
   parameter int ID_W = 11,
   localparam int IW  = $clog2(NMB),
   localparam int CW  = $clog2(NMB + 2)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [ID_W-1:0]           id_in,
   input  logic                      remote_in,
   input  logic [NMB-1:0][ID_W-1:0]  mb_id,
   input  logic [NMB-1:0][ID_W-1:0]  mb_msk,
   input  logic [NMB-1:0]            mb_en,
   input  logic [NMB-1:0]            mb_rtr,
   output logic                      busy,
   output logic                      store_vld,
   output logic [IW-1:0]             store_idx
);
   logic [IW-1:0]   cur;
   logic [ID_W-1:0] lat_id;
   logic            lat_rem;
   logic            hit;

   always_comb begin
      hit = mb_en[cur] && (mb_rtr[cur] == lat_rem) &&
            (((lat_id ^ mb_id[cur]) & ~mb_msk[cur]) == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         store_vld <= 1'b0;
         store_idx <= '0;
         cur       <= '0;
         lat_id    <= '0;
         lat_rem   <= 1'b0;
      end else begin
         store_vld <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy    <= 1'b1;
               cur     <= IW'(NMB - 1);
               lat_id  <= id_in;
               lat_rem <= remote_in;
            end
         end else if (hit) begin
            store_vld <= 1'b1;
            store_idx <= cur;
            busy      <= 1'b0;
         end else if (cur == '0) begin
            busy <= 1'b0;
         end else begin
            cur <= cur - 1'b1;
         end
      end
   end

   // search length watch
   logic [CW-1:0] scan_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    scan_len <= '0;
      else if (busy) scan_len <= scan_len + 1'b1;
      else            scan_len <= '0;
   end

   p_scan_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      scan_len <= CW'(NMB));
   p_store_from_search_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(store_vld) |-> $fell(busy));
endmodule

// File: rtl/canf_flags.sv
module canf_flags #(
   parameter int NMB = 32,
   localparam int IW = $clog2(NMB)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           store_vld,
   input  logic [IW-1:0]  store_idx,
   input  logic           clr_we,
   input  logic [NMB-1:0] clr_bits,
   input  logic           ie_we,
   input  logic [NMB-1:0] ie_wdata,
   input  logic           gie_we,
   input  logic           gie_wdata,
   output logic [NMB-1:0] done,
   output logic           irq
);
   logic [NMB-1:0] ie;
   logic           gie;
   logic [NMB-1:0] set_vec;
   logic [NMB-1:0] clr_vec;

   always_comb begin
      set_vec = '0;
      if (store_vld) set_vec[store_idx] = 1'b1;
      clr_vec = clr_we ? clr_bits : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done <= '0;
         ie   <= '0;
         gie  <= 1'b0;
      end else begin
         done <= (done & ~clr_vec) | set_vec;
         if (ie_we)  ie  <= ie_wdata;
         if (gie_we) gie <= gie_wdata;
      end
   end

   assign irq = gie && ((done & ie) != '0);

   p_done_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      store_vld |=> done[$past(store_idx)]);
   p_irq_follows_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (store_vld && gie && ie[store_idx] && !gie_we && !ie_we) |=> irq);
endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter #(
   parameter int NMB  = 32,
   parameter int ID_W = 11,
   localparam int IW  = $clog2(NMB)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [1:0]      cfg_sel,
   input  logic [IW-1:0]   cfg_idx,
   input  logic [ID_W-1:0] cfg_wdata,
   input  logic            irq_mb_we,
   input  logic [NMB-1:0]  irq_mb_wdata,
   input  logic            irq_gen_we,
   input  logic            irq_gen_wdata,
   input  logic            done_clr_we,
   input  logic [NMB-1:0]  done_clr,
   input  logic [ID_W-1:0] frm_id,
   input  logic            frm_remote,
   input  logic            crc_ok,
   output logic            ack,
   output logic            busy,
   output logic            store_vld,
   output logic [IW-1:0]   store_idx,
   output logic [NMB-1:0]  rx_done,
   output logic            rx_irq
);
   if (NMB < 2) begin : g_bad_nmb
      $error("rx_accept_filter: NMB must be at least 2");
   end
   if (ID_W < 1) begin : g_bad_idw
      $error("rx_accept_filter: ID_W must be positive");
   end

   logic [NMB-1:0][ID_W-1:0] mb_id;
   logic [NMB-1:0][ID_W-1:0] mb_msk;
   logic [NMB-1:0]           mb_en;
   logic [NMB-1:0]           mb_rtr;

   canf_cfg_bank #(.NMB(NMB), .ID_W(ID_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .idx(cfg_idx),
      .wdata(cfg_wdata), .mb_id(mb_id), .mb_msk(mb_msk), .mb_en(mb_en),
      .mb_rtr(mb_rtr)
   );

   canf_scan #(.NMB(NMB), .ID_W(ID_W)) u_scan (
      .clk(clk), .rst_n(rst_n), .start(crc_ok), .id_in(frm_id),
      .remote_in(frm_remote), .mb_id(mb_id), .mb_msk(mb_msk), .mb_en(mb_en),
      .mb_rtr(mb_rtr), .busy(busy), .store_vld(store_vld),
      .store_idx(store_idx)
   );

   canf_flags #(.NMB(NMB)) u_flags (
      .clk(clk), .rst_n(rst_n), .store_vld(store_vld), .store_idx(store_idx),
      .clr_we(done_clr_we), .clr_bits(done_clr), .ie_we(irq_mb_we),
      .ie_wdata(irq_mb_wdata), .gie_we(irq_gen_we), .gie_wdata(irq_gen_wdata),
      .done(rx_done), .irq(rx_irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack <= 1'b0;
      else        ack <= crc_ok;
   end

   p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_ok && !busy) |=> busy);
endmodule

// File: tb/tb_rx_accept_filter.sv
module tb_rx_accept_filter;
   localparam int NMB = 32;
   localparam int IDW = 11;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_we = 0;
   logic [1:0]      cfg_sel = 0;
   logic [4:0]      cfg_idx = 0;
   logic [IDW-1:0]  cfg_wdata = 0;
   logic            irq_mb_we = 0;
   logic [NMB-1:0]  irq_mb_wdata = 0;
   logic            irq_gen_we = 0;
   logic            irq_gen_wdata = 0;
   logic            done_clr_we = 0;
   logic [NMB-1:0]  done_clr = 0;
   logic [IDW-1:0]  frm_id = 0;
   logic            frm_remote = 0;
   logic            crc_ok = 0;
   logic            ack, busy, store_vld, rx_irq;
   logic [4:0]      store_idx;
   logic [NMB-1:0]  rx_done;

   rx_accept_filter dut (.*);

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;

   logic [IDW-1:0] m_id  [NMB];
   logic [IDW-1:0] m_msk [NMB];
   logic           m_en  [NMB];
   logic           m_rtr [NMB];
   logic [NMB-1:0] m_done = '0;
   logic [NMB-1:0] m_ie = '0;
   logic           m_gie = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int pick(input logic [IDW-1:0] id, input logic rem);
      for (int k = NMB - 1; k >= 0; k--)
         if (m_en[k] && m_rtr[k] == rem && (((id ^ m_id[k]) & ~m_msk[k]) == '0))
            return k;
      return -1;
   endfunction

   task automatic wr_cfg(input int sel, input int idx, input int data);
      @(negedge clk);
      cfg_we = 1; cfg_sel = 2'(sel); cfg_idx = 5'(idx); cfg_wdata = IDW'(data);
      @(negedge clk);
      cfg_we = 0;
      case (sel)
         0: m_id[idx] = IDW'(data);
         1: m_msk[idx] = IDW'(data);
         default: begin m_en[idx] = data[0]; m_rtr[idx] = data[1]; end
      endcase
   endtask

   task automatic wr_ie(input logic [NMB-1:0] v, input logic g);
      @(negedge clk);
      irq_mb_we = 1; irq_mb_wdata = v; irq_gen_we = 1; irq_gen_wdata = g;
      @(negedge clk);
      irq_mb_we = 0; irq_gen_we = 0;
      m_ie = v; m_gie = g;
   endtask

   task automatic clr_done(input logic [NMB-1:0] v);
      @(negedge clk);
      done_clr_we = 1; done_clr = v;
      @(negedge clk);
      done_clr_we = 0;
      m_done = m_done & ~v;
      chk(rx_done == m_done, "R7 clear", int'(rx_done), int'(m_done));
   endtask

   task automatic frame(input logic [IDW-1:0] id, input logic rem, input string tag);
      int exp, got, cyc, nst;
      exp = pick(id, rem);
      got = -1; cyc = 0; nst = 0;
      @(negedge clk);
      frm_id = id; frm_remote = rem; crc_ok = 1;
      @(negedge clk);
      crc_ok = 0;
      chk(ack == 1'b1, "R4 ack", int'(ack), 1);
      chk(busy == 1'b1, "R6 busy", int'(busy), 1);
      while (cyc < 40) begin
         @(negedge clk);
         cyc++;
         if (store_vld) begin got = int'(store_idx); nst++; end
         if (!busy) break;
      end
      chk(cyc <= NMB, "R6 bound", cyc, NMB);
      chk(got == exp, {tag, " index"}, got, exp);
      chk(nst == (exp >= 0 ? 1 : 0), "R9/R6 strobe count", nst, exp >= 0 ? 1 : 0);
      if (exp >= 0) m_done[exp] = 1'b1;
      @(negedge clk);
      chk(rx_done == m_done, "R7 done", int'(rx_done), int'(m_done));
      chk(rx_irq == (m_gie && ((m_done & m_ie) != '0)), "R8 irq", int'(rx_irq),
          int'(m_gie && ((m_done & m_ie) != '0)));
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL R6 watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int sc;
      void'($urandom(32'd7));
      for (int k = 0; k < NMB; k++) begin m_id[k] = 0; m_msk[k] = 0; m_en[k] = 0; m_rtr[k] = 0; end
      repeat (3) @(negedge clk);
      // R10 reset state
      chk({ack, busy, store_vld, rx_irq} == 4'b0, "R10 outputs", int'({ack, busy, store_vld, rx_irq}), 0);
      chk(rx_done == '0, "R10 done", int'(rx_done), 0);
      rst_n = 1;
      @(negedge clk);
      frame(11'h2AA, 1'b0, "R10 all disabled");

      // R1 R2 directed
      wr_cfg(0, 1, 11'h2AA); wr_cfg(1, 1, 0); wr_cfg(2, 1, 1);
      wr_cfg(0, 0, 11'h2AA); wr_cfg(1, 0, 11'h003); wr_cfg(2, 0, 1);
      wr_ie(32'h1, 1'b1);
      frame(11'h2A9, 1'b0, "R1 masked low bits");
      frame(11'h2AB, 1'b0, "R1 masked low bits");
      frame(11'h2A8, 1'b0, "R1 masked low bits");
      frame(11'h2AA, 1'b0, "R2 highest wins");
      frame(11'h2AC, 1'b0, "R9 no match");
      frame(11'h2AA, 1'b1, "R5 type mismatch");
      clr_done(32'h3);
      wr_cfg(2, 1, 0);
      frame(11'h2AA, 1'b0, "R5 disabled");
      wr_cfg(2, 1, 3);
      frame(11'h2AA, 1'b1, "R5 remote accepted");

      // R3 identifier without strobe
      sc = 0;
      @(negedge clk); frm_id = 11'h2AA; frm_remote = 0;
      repeat (40) begin @(negedge clk); if (store_vld || busy) sc++; end
      chk(sc == 0, "R3 no strobe", sc, 0);
      chk(rx_done == m_done, "R3 done unchanged", int'(rx_done), int'(m_done));

      // R6 strobe while busy ignored: long search to mailbox 0
      wr_cfg(2, 1, 0);
      wr_cfg(0, 31, 11'h155); wr_cfg(1, 31, 0); wr_cfg(2, 31, 1);
      begin
         int got, nst, cyc;
         got = -1; nst = 0; cyc = 0;
         @(negedge clk); frm_id = 11'h2A8; frm_remote = 0; crc_ok = 1;
         @(negedge clk); crc_ok = 0;
         @(negedge clk); frm_id = 11'h155; crc_ok = 1;
         @(negedge clk); crc_ok = 0;
         chk(ack == 1'b1, "R4 ack while busy", int'(ack), 1);
         if (store_vld) begin got = int'(store_idx); nst++; end
         while (cyc < 40) begin
            @(negedge clk); cyc++;
            if (store_vld) begin got = int'(store_idx); nst++; end
            if (!busy) break;
         end
         chk(got == 0 && nst == 1, "R6 busy ignore", got, 0);
         m_done[0] = 1'b1;
         @(negedge clk);
         chk(rx_done == m_done, "R7 done after ignore", int'(rx_done), int'(m_done));
      end

      // random tables
      clr_done('1);
      for (int t = 0; t < 4; t++) begin
         for (int k = 0; k < NMB; k++) begin
            wr_cfg(0, k, int'($urandom_range(0, 2047)));
            wr_cfg(1, k, ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 2047)) : int'($urandom_range(0, 15)));
            wr_cfg(2, k, int'($urandom_range(0, 3)));
         end
         wr_ie($urandom(), 1'($urandom_range(0, 1)));
         for (int f = 0; f < 40; f++) begin
            logic [IDW-1:0] id;
            int src;
            src = int'($urandom_range(0, NMB - 1));
            if ($urandom_range(0, 3) == 0) id = IDW'($urandom_range(0, 2047));
            else id = m_id[src] ^ (IDW'($urandom_range(0, 2047)) & (($urandom_range(0, 1) == 1) ? m_msk[src] : IDW'(1 << $urandom_range(0, IDW - 1))));
            frame(id, m_rtr[src], "R1/R2 random");
            if (f % 10 == 9) clr_done(NMB'($urandom()));
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule